// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

This block is a register-mapped timer with two channels. Each channel owns a 32-bit up-counter and a 32-bit compare value. A single control word holds one enable flag and one pending flag per channel. While a channel is enabled, its counter advances by one every clock. When the count equals the compare value, the channel latches its pending flag and raises its own interrupt line.

Software drives the block over a plain register bus: a byte address, a write strobe and write data go in, and read data comes back combinationally. To arm an event, software reads the counter, adds a delta and writes the sum into the compare register. Any write to a compare register also acknowledges that channel's interrupt, so the usual service step is to copy the current count into the compare register. Counters can also be loaded directly.

Top module: `cmt_pair_timer`

## Requirements
- R1: After reset, both counters read 0, both compare registers read 0xFFFFFFFF, the control word reads 0 and both interrupt lines are low.
- R2: The register map uses full byte addresses: control at 0x00, channel 0 compare at 0x04, channel 0 count at 0x08, channel 1 compare at 0x0C and channel 1 count at 0x10. Channel n compare sits at 0x04+8n and its count at 0x08+8n.
- R3: When control bit n (enable) is 1, counter n increases by exactly 1 on each clock edge. When the bit is 0, counter n holds its value.
- R4: A write to a count address loads the written value on that edge, whether or not the channel is enabled. Counting then resumes from the loaded value.
- R5: A counter wraps from 0xFFFFFFFF to 0x00000000.
- R6: On an edge where channel n is enabled and its count equals its compare value, pending flag n sets. From the next cycle it reads as control bit 16+n, and irq[n] is high.
- R7: A set pending flag stays set until its channel's compare register is written. That write clears it from the next cycle, and the clear takes priority over a match on the same edge.
- R8: A pending flag never sets while its enable bit is 0, even when the count equals the compare value.
- R9: Control writes change only bits 0 and 1. Writes to the pending bits 16 and 17 are ignored, and every other control bit reads as 0.
- R10: The channels are independent. Activity on one channel never changes the other channel's counter, compare value, pending flag or interrupt.
- R11: Any address other than the five listed in R2, including unaligned ones, reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one edge per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 2 | Interrupt per channel, high while its pending flag is set |

## Verification
A wrong counter state shows directly as an off-by-n value the next time the count register is read, one cycle after any edge. A wrong compare value or a wrong enable gating shows as an interrupt that rises one cycle early or late, or not at all. Sweeping the compare distance cycle by cycle pins this timing exactly. A pending flag that is lost or left stuck shows on irq and on control bits 16 and 17 in the cycle after the faulty edge.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int NUM_CH   = 2;
    localparam int PEND_LSB = 16;
    localparam int CTL_OFF  = 0;

    function automatic int cmp_off(input int ch);
        return 4 + 8 * ch;
    endfunction

    function automatic int cnt_off(input int ch);
        return 8 + 8 * ch;
    endfunction
endpackage

// File: rtl/cmt_addr_dec.sv
module cmt_addr_dec #(
    parameter int ADDR_W = 5,
    parameter int NUM_CH = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_ctl,
    output logic [NUM_CH-1:0] sel_cmp,
    output logic [NUM_CH-1:0] sel_cnt
);
    assign sel_ctl = (addr == ADDR_W'(cmt_pkg::CTL_OFF));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign sel_cmp[g] = (addr == ADDR_W'(cmt_pkg::cmp_off(g)));
        assign sel_cnt[g] = (addr == ADDR_W'(cmt_pkg::cnt_off(g)));
    end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_cmp,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] compare,
    output logic             pend
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             pend;
    } chan_t;

    chan_t s_q, s_d;
    logic  hit;

    always_comb begin
        s_d = s_q;
        hit = en && (s_q.cnt == s_q.cmp);
        if (wr_cnt) begin
            s_d.cnt = wdata;
        end else if (en) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (wr_cmp) begin
            s_d.cmp  = wdata;
            s_d.pend = 1'b0;
        end else if (hit) begin
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, cmp: '1, pend: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign count   = s_q.cnt;
    assign compare = s_q.cmp;
    assign pend    = s_q.pend;
endmodule

// File: rtl/cmt_pair_timer.sv
module cmt_pair_timer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_we,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic [cmt_pkg::NUM_CH-1:0]     irq
);
    localparam int NUM_CH   = cmt_pkg::NUM_CH;
    localparam int PEND_LSB = cmt_pkg::PEND_LSB;

    typedef struct packed {
        logic [NUM_CH-1:0] en;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic                          sel_ctl;
    logic [NUM_CH-1:0]             sel_cmp;
    logic [NUM_CH-1:0]             sel_cnt;
    logic [NUM_CH-1:0]             pend_w;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_w;
    logic [NUM_CH-1:0][DATA_W-1:0] cmp_w;

    cmt_addr_dec #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH)
    ) i_dec (
        .addr    (bus_addr),
        .sel_ctl (sel_ctl),
        .sel_cmp (sel_cmp),
        .sel_cnt (sel_cnt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cmt_channel #(
            .CNT_W (DATA_W)
        ) i_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ctl_q.en[g]),
            .wr_cmp  (bus_we && sel_cmp[g]),
            .wr_cnt  (bus_we && sel_cnt[g]),
            .wdata   (bus_wdata),
            .count   (cnt_w[g]),
            .compare (cmp_w[g]),
            .pend    (pend_w[g])
        );
    end

    always_comb begin
        ctl_d = ctl_q;
        if (bus_we && sel_ctl) begin
            ctl_d.en = bus_wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctl) begin
            bus_rdata[NUM_CH-1:0]          = ctl_q.en;
            bus_rdata[PEND_LSB +: NUM_CH]  = pend_w;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_cmp[i]) bus_rdata = cmp_w[i];
            if (sel_cnt[i]) bus_rdata = cnt_w[i];
        end
    end

    assign irq = pend_w;
endmodule

// File: rtl/cmt_pair_timer_chk.sv
module cmt_pair_timer_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int NUM_CH = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic                           bus_we,
    input logic [DATA_W-1:0]              bus_wdata,
    input logic [DATA_W-1:0]              bus_rdata,
    input logic [NUM_CH-1:0]              irq,
    input logic [NUM_CH-1:0]              en,
    input logic [NUM_CH-1:0][DATA_W-1:0]  cnt
);
    localparam int PEND_LSB = cmt_pkg::PEND_LSB;

    always_comb begin
        if (rst_n && bus_addr == ADDR_W'(cmt_pkg::CTL_OFF)) begin
            assert_rsv_zero_R9: assert (bus_rdata[PEND_LSB-1:NUM_CH] == '0 &&
                                        bus_rdata[DATA_W-1:PEND_LSB+NUM_CH] == '0);
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] CMPA = ADDR_W'(cmt_pkg::cmp_off(g));
        localparam logic [ADDR_W-1:0] CNTA = ADDR_W'(cmt_pkg::cnt_off(g));

        assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == CMPA) |=> !irq[g]);

        assert_pend_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[g] && !(bus_we && bus_addr == CMPA)) |=> irq[g]);

        assert_no_set_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[g] && !irq[g]) |=> !irq[g]);

        assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (en[g] && !(bus_we && bus_addr == CNTA)) |=>
            (cnt[g] == DATA_W'($past(cnt[g]) + 1'b1)));

        assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[g] && !(bus_we && bus_addr == CNTA)) |=> $stable(cnt[g]));

        assert_count_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == CNTA) |=> (cnt[g] == $past(bus_wdata)));
    end
endmodule

bind cmt_pair_timer cmt_pair_timer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_CH (cmt_pkg::NUM_CH)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .en        (ctl_q.en),
    .cnt       (cnt_w)
);

// File: tb/test_cmt_pair_timer.sv
module test_cmt_pair_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmt_pair_timer i_cmt_pair_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr  = 5'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 5'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit mapped(input int a);
        return (a == 0 || a == 4 || a == 8 || a == 12 || a == 16);
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] v;
        logic [31:0] pat [5];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents across the whole address space (R11 for holes)
        for (int a = 0; a < 32; a++) begin
            rd(a, r);
            chk(mapped(a) ? "R1" : "R11", r, (a == 4 || a == 12) ? 32'hFFFF_FFFF : 32'h0);
        end
        chk("R1 irq", {30'd0, irq}, 32'h0);

        // R2: distinct patterns at each data register, channels disabled
        pat[1] = 32'h1111_0004; pat[2] = 32'h2222_0008;
        pat[3] = 32'h3333_000C; pat[4] = 32'h4444_0010;
        for (int i = 1; i < 5; i++) wr(4 * i, pat[i]);
        for (int i = 1; i < 5; i++) begin
            rd(4 * i, r);
            chk("R2", r, pat[i]);
        end

        // R11: writes to every unmapped address are ignored
        for (int a = 0; a < 32; a++) begin
            if (!mapped(a)) wr(a, 32'hDEAD_BEEF);
        end
        for (int i = 1; i < 5; i++) begin
            rd(4 * i, r);
            chk("R11", r, pat[i]);
        end
        rd(0, r);
        chk("R11 ctl", r, 32'h0);

        // R9: pending bits not writable, reserved bits read 0
        wr(0, 32'hFFFF_FFFC);
        rd(0, r);
        chk("R9", r, 32'h0);
        chk("R9 irq", {30'd0, irq}, 32'h0);
        wr(0, 32'hFFFF_FFFF);
        rd(0, r);
        chk("R9", r, 32'h0000_0003);
        wr(0, 32'h0);

        // R3 / R10: counting with channel 0 only
        wr(8, 32'd100);
        wr(16, 32'd500);
        wr(0, 32'h1);
        for (int n = 0; n < 5; n++) begin
            rd(8, r);
            chk("R3", r, 32'd100 + 32'(n));
            rd(16, r);
            chk("R10", r, 32'd500);
            tick(1);
        end
        wr(0, 32'h0);
        rd(8, v);
        tick(3);
        rd(8, r);
        chk("R3 hold", r, v);

        // R4: direct load while enabled
        wr(0, 32'h1);
        wr(8, 32'h0000_5000);
        rd(8, r);
        chk("R4", r, 32'h0000_5000);
        tick(1);
        rd(8, r);
        chk("R4", r, 32'h0000_5001);

        // R5: wrap
        wr(8, 32'hFFFF_FFFE);
        rd(8, r);
        chk("R5", r, 32'hFFFF_FFFE);
        tick(1); rd(8, r); chk("R5", r, 32'hFFFF_FFFF);
        tick(1); rd(8, r); chk("R5", r, 32'h0000_0000);
        tick(1); rd(8, r); chk("R5", r, 32'h0000_0001);

        // R6 / R7 / R10: compare distance sweep on both channels
        for (int ch = 0; ch < 2; ch++) begin
            for (int k = 0; k < 6; k++) begin
                v = 32'h1000 * 32'(k + 1) + 32'(ch);
                wr(0, 32'h0);
                wr(4 + 8 * ch, v + 32'(k));
                wr(8 + 8 * ch, v);
                wr(0, 32'(1 << ch));
                tick(k);
                chk("R6 early", {30'd0, irq}, 32'h0);
                tick(1);
                chk("R6 rise", {30'd0, irq}, 32'(1 << ch));
                rd(0, r);
                chk("R6 ctl", r, 32'(1 << ch) | 32'(1 << (16 + ch)));
                rd(8 + 8 * ch, r);
                chk("R6 cnt", r, v + 32'(k + 1));
                tick(3);
                chk("R7 hold", {30'd0, irq}, 32'(1 << ch));
                rd(8 + 8 * ch, r);
                wr(4 + 8 * ch, r);
                chk("R7 ack", {30'd0, irq}, 32'h0);
                tick(2);
                chk("R7 quiet", {30'd0, irq}, 32'h0);
            end
        end

        // R8: equal count and compare while disabled
        wr(0, 32'h0);
        wr(4, 32'h0000_0777);
        wr(8, 32'h0000_0777);
        tick(5);
        chk("R8 irq", {30'd0, irq}, 32'h0);
        rd(0, r);
        chk("R8 ctl", r, 32'h0);
        wr(0, 32'h1);
        tick(1);
        chk("R8 enable", {30'd0, irq}, 32'h1);
        wr(4, 32'h0);
        chk("R8 ack", {30'd0, irq}, 32'h0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule